// File: doc/BRIEF.md
# Decibel-to-Linear Gain Converter

This block turns a signed decibel figure into a linear amplitude factor. It first scales the dB value by ln(10)/20 to form a natural exponent argument, and then evaluates e^x with integer arithmetic only. Arguments outside a fixed window are resolved at once to zero or to full scale. Any other argument is halved until it lies strictly inside (-2, +2). A ten-step power series is then run on the halved value, with one sequential division per term. The halving is undone by multiplying an accumulator by the series result 2^n times.

A caller drives a dB code on `db_i` and pulses `start_i` while the unit is idle. `busy_o` stays high until the conversion ends. `done_o` is high for exactly one cycle when `result_o` is updated, and `result_o` then holds that value until a later conversion completes. A `start_i` pulse that arrives while the unit is busy is dropped. Every shift between fixed-point formats rounds half up: half an LSB of the discarded part is added before an arithmetic right shift.

Top module: `db_exp_unit`

## Requirements
- R1: `db_i` is signed Q8.24. Any code below -100 dB (-1677721600) produces a result of exactly 0.
- R2: Otherwise `result_o` is unsigned Q12.20 and approximates 2^20 · e^(db·ln10/20), within 16 LSB plus 2e-4 of the ideal value.
- R3: When the exponent argument (Q5.27, rounded) is below -11.5, the result is exactly 0. For example, -99.95 dB gives 0.
- R4: When the exponent argument is above 7.6245, the result is exactly 0x7FFFFFFF.
- R5: An input of 0 dB gives exactly 1.0, which is 0x00100000.
- R6: The R2 accuracy holds whether the argument needs zero, one, two or three halvings, for both positive and negative arguments.
- R7: After reset, `busy_o`, `done_o` and `result_o` are 0. `busy_o` rises on the cycle after an accepted `start_i`. `done_o` is high for a single cycle, and `busy_o` is low on the cycle after that.
- R8: `result_o` changes only in a cycle where `done_o` is high. It holds its value while `db_i` changes and no new start is accepted.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. It neither changes the result in progress nor produces an extra `done_o`.
- R10: A completed result never has bit 31 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a conversion when the unit is idle |
| db_i | input | 32 | Gain in dB, signed Q8.24 |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| result_o | output | 32 | Linear gain, Q12.20 |

## Verification
The bench pairs codes on both sides of each cutoff. -100.5 dB and -99.95 dB must give exactly zero, while -99.8 dB must give a few LSB. 66.3 dB must saturate, while 66.2 dB must give a value just under full scale. A design with a misplaced threshold or a reversed comparison would put out a small non-zero value or a wrapped value where an exact constant is due. Inputs of 40, 60, -60 and -80 dB force two or three halvings. A wrong halving count or a wrong number of reconstruction multiplies would square or halve the gain and land far outside tolerance. 0 dB must give exactly 1.0, which catches a wrong rounding offset or a missing unit term. A second start pulse sent in the middle of a conversion would change the result or add a second done pulse if the busy guard were missing.

// File: rtl/db_exp_pkg.sv
package db_exp_pkg;
  localparam int DATA_W = 32;
  localparam int LAST_TERM = 11;

  localparam logic signed [DATA_W-1:0] DB_FLOOR     = -32'sd1677721600; // -100.0 Q8.24
  localparam logic signed [DATA_W-1:0] LN10_DIV20   = 32'sd15452387;    // ln(10)/20 Q5.27
  localparam logic signed [DATA_W-1:0] ARG_LO       = -32'sd1543503872; // -11.5 Q5.27
  localparam logic signed [DATA_W-1:0] ARG_HI       = 32'sd1023343067;  // 7.6245 Q5.27
  localparam logic signed [DATA_W-1:0] TWO_Q27      = 32'sd268435456;
  localparam logic signed [DATA_W-1:0] LIM_Q29      = 32'sd1073741824;  // 2.0 Q3.29
  localparam logic signed [DATA_W-1:0] ONE_Q23      = 32'sd8388608;
  localparam logic signed [DATA_W-1:0] ONE_Q20      = 32'sd1048576;
  localparam logic signed [DATA_W-1:0] SAT_VAL      = 32'sh7FFFFFFF;

  typedef enum logic [3:0] {
    S_IDLE, S_ARG, S_LIM, S_RED, S_MUL, S_DGO, S_DWAIT, S_SUM, S_REC, S_FIN
  } conv_state_e;
endpackage

// File: rtl/db_exp_rnd_mul.sv
module db_exp_rnd_mul #(
  parameter int A_W   = 32,
  parameter int B_W   = 32,
  parameter int SHIFT = 20,
  parameter int Y_W   = 32
) (
  input  logic signed [A_W-1:0] a_i,
  input  logic signed [B_W-1:0] b_i,
  output logic signed [Y_W-1:0] y_o
);
  localparam int P_W = A_W + B_W;
  localparam logic signed [P_W-1:0] HALF = {{(P_W-1){1'b0}}, 1'b1} << (SHIFT-1);

  logic signed [P_W-1:0] prod;

  assign prod = a_i * b_i;
  // round half up, then arithmetic shift back to the target format
  assign y_o  = Y_W'((prod + HALF) >>> SHIFT);
endmodule

// File: rtl/db_exp_divider.sv
module db_exp_divider #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DEN_W-1:0] divisor_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quotient_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= CNT_W'(NUM_W);
        rem_q <= '0;
        den_q <= divisor_i;
        quo_q <= dividend_i;
      end else if (run_q) begin
        quo_q <= {quo_q[NUM_W-2:0], ge};
        rem_q <= ge ? DEN_W'(diff) : DEN_W'(trial);
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign quotient_o = quo_q;

  // R2: restoring step leaves a remainder below the divisor
  a_r2_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < den_q));
endmodule

// File: rtl/db_exp_unit.sv
module db_exp_unit
  import db_exp_pkg::*;
#(
  parameter int POW_W  = 48,
  parameter int N_W    = 4,
  parameter int ITER_W = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] db_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] result_o
);
  conv_state_e state_q;

  logic signed [DATA_W-1:0] db_q, arg_q, xs_q, x29_q, sum_q, z_q, acc_q, res_q;
  logic signed [POW_W-1:0]  pow_q;
  logic [DATA_W-1:0]        den_q;
  logic [3:0]               k_q;
  logic [N_W-1:0]           n_q;
  logic [ITER_W-1:0]        rcnt_q;

  logic signed [DATA_W-1:0] arg_w, rec_w, q23_w, z_w, quo32, inc_w;
  logic signed [POW_W-1:0]  pow_w;
  logic [POW_W-1:0]         pow_mag, quo_w;
  logic                     div_done, xs_big;

  db_exp_rnd_mul #(.A_W(DATA_W), .B_W(DATA_W), .SHIFT(24), .Y_W(DATA_W)) u_arg (
    .a_i(db_q), .b_i(LN10_DIV20), .y_o(arg_w));

  db_exp_rnd_mul #(.A_W(POW_W), .B_W(DATA_W), .SHIFT(29), .Y_W(POW_W)) u_pow (
    .a_i(pow_q), .b_i(x29_q), .y_o(pow_w));

  db_exp_rnd_mul #(.A_W(DATA_W), .B_W(DATA_W), .SHIFT(20), .Y_W(DATA_W)) u_rec (
    .a_i(acc_q), .b_i(z_q), .y_o(rec_w));

  assign pow_mag = pow_q[POW_W-1] ? POW_W'(-pow_q) : POW_W'(pow_q);

  db_exp_divider #(.NUM_W(POW_W), .DEN_W(DATA_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (state_q == S_DGO),
    .dividend_i(pow_mag),
    .divisor_i (den_q),
    .done_o    (div_done),
    .quotient_o(quo_w)
  );

  assign quo32  = 32'(quo_w);
  assign inc_w  = pow_q[POW_W-1] ? -quo32 : quo32;
  assign xs_big = (xs_q >= TWO_Q27) || (xs_q <= -TWO_Q27);
  assign q23_w  = (xs_q + 32'sd8) >>> 4;                // Q5.27 -> Q9.23
  assign z_w    = (sum_q + ONE_Q23 + 32'sd4) >>> 3;     // Q9.23 -> Q12.20

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      db_q    <= '0;
      arg_q   <= '0;
      xs_q    <= '0;
      x29_q   <= '0;
      sum_q   <= '0;
      z_q     <= '0;
      acc_q   <= '0;
      res_q   <= '0;
      pow_q   <= '0;
      den_q   <= '0;
      k_q     <= '0;
      n_q     <= '0;
      rcnt_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          db_q    <= db_i;
          state_q <= S_ARG;
        end
        S_ARG: if (db_q < DB_FLOOR) begin
          res_q   <= '0;
          state_q <= S_FIN;
        end else begin
          arg_q   <= arg_w;
          state_q <= S_LIM;
        end
        S_LIM: if (arg_q < ARG_LO) begin
          res_q   <= '0;
          state_q <= S_FIN;
        end else if (arg_q > ARG_HI) begin
          res_q   <= SAT_VAL;
          state_q <= S_FIN;
        end else begin
          xs_q    <= arg_q;
          n_q     <= '0;
          state_q <= S_RED;
        end
        S_RED: if (xs_big) begin
          xs_q <= xs_q >>> 1;
          n_q  <= n_q + 1'b1;
        end else begin
          x29_q   <= xs_q <<< 2;
          pow_q   <= {{(POW_W-DATA_W){q23_w[DATA_W-1]}}, q23_w};
          sum_q   <= q23_w;
          den_q   <= 32'd1;
          k_q     <= 4'd2;
          state_q <= S_MUL;
        end
        S_MUL: begin
          pow_q   <= pow_w;
          den_q   <= den_q * 32'(k_q);
          state_q <= S_DGO;
        end
        S_DGO: state_q <= S_DWAIT;
        S_DWAIT: if (div_done) begin
          sum_q <= sum_q + inc_w;
          if (k_q == 4'(LAST_TERM)) begin
            state_q <= S_SUM;
          end else begin
            k_q     <= k_q + 4'd1;
            state_q <= S_MUL;
          end
        end
        S_SUM: begin
          z_q     <= z_w;
          acc_q   <= ONE_Q20;
          rcnt_q  <= ITER_W'(1) << n_q;
          state_q <= S_REC;
        end
        S_REC: if (rcnt_q == '0) begin
          res_q   <= acc_q;
          state_q <= S_FIN;
        end else begin
          acc_q  <= rec_w;
          rcnt_q <= rcnt_q - 1'b1;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != S_IDLE;
  assign done_o   = state_q == S_FIN;
  assign result_o = res_q;

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);

  a_r10_non_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !result_o[31]);

  a_r6_reduced_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MUL) |-> ((x29_q < LIM_Q29) && (x29_q > -LIM_Q29)));
endmodule

// File: tb/db_exp_unit_bench.sv
module db_exp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OP_TIMEOUT = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] db = '0;
  logic        busy, done;
  logic [31:0] res;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  db_exp_unit u_db_exp_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .db_i(db),
    .busy_o(busy), .done_o(done), .result_o(res));

  task automatic chk(string req, bit ok, string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  function automatic logic [31:0] to_code(real dbv);
    return 32'($rtoi(dbv * 16777216.0));
  endfunction

  task automatic convert(input logic [31:0] code, output logic [31:0] r, output bit tout);
    @(negedge clk);
    db = code; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tout = 1'b1;
    for (int i = 0; i < OP_TIMEOUT; i++) begin
      if (done) begin tout = 1'b0; break; end
      @(negedge clk);
    end
    r = res;
  endtask

  task automatic model(input logic [31:0] code, output real e, output bit exact);
    real dbv, arg;
    dbv = $itor($signed(code)) / 16777216.0;
    arg = dbv * $ln(10.0) / 20.0;
    exact = 1'b1;
    if ($signed(code) < -32'sd1677721600) e = 0.0;
    else if (arg < -11.5) e = 0.0;
    else if (arg > 7.6245) e = 2147483647.0;
    else begin e = $exp(arg) * 1048576.0; exact = 1'b0; end
  endtask

  task automatic run_value(string req, real dbv);
    logic [31:0] r, code;
    bit tout, exact;
    real e, diff, tol;
    code = to_code(dbv);
    convert(code, r, tout);
    chk(req, !tout, $sformatf("timeout at %f dB actual=busy expected=done", dbv));
    model(code, e, exact);
    if (exact) begin
      chk(req, r == 32'($rtoi(e)), $sformatf("%f dB actual=%0d expected=%0d", dbv, r, $rtoi(e)));
    end else begin
      diff = $itor(r) - e;
      if (diff < 0.0) diff = -diff;
      tol = 16.0 + 2.0e-4 * e;
      chk(req, diff <= tol, $sformatf("%f dB actual=%0d expected=%f", dbv, r, e));
    end
    chk("R10", !r[31], $sformatf("%f dB actual=%h expected bit31=0", dbv, r));
  endtask

  task automatic test_reset();
    chk("R7", !busy && !done && res == 32'd0,
        $sformatf("reset actual=%b/%b/%h expected=0/0/0", busy, done, res));
  endtask

  task automatic test_floor();
    run_value("R1", -100.5);
    run_value("R1", -127.0);
  endtask

  task automatic test_arg_limits();
    run_value("R3", -99.95);
    run_value("R4", 66.3);
    run_value("R4", 127.9);
  endtask

  task automatic test_unity();
    logic [31:0] r;
    bit tout;
    convert(32'd0, r, tout);
    chk("R5", !tout && r == 32'h0010_0000, $sformatf("actual=%h expected=00100000", r));
  endtask

  task automatic test_accuracy();
    run_value("R2", -6.0);
    run_value("R2", 6.0206);
    run_value("R2", 3.5);
    run_value("R2", -20.0);
    run_value("R2", 20.0);
  endtask

  task automatic test_halvings();
    run_value("R6", 12.0);
    run_value("R6", 40.0);
    run_value("R6", 60.0);
    run_value("R6", 66.2);
    run_value("R6", -60.0);
    run_value("R6", -80.0);
    run_value("R6", -99.8);
  endtask

  task automatic test_handshake();
    int done_cnt;
    @(negedge clk);
    db = to_code(10.0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", busy == 1'b1, $sformatf("busy after start actual=%b expected=1", busy));
    for (int i = 0; i < OP_TIMEOUT && !done; i++) @(negedge clk);
    chk("R7", done == 1'b1, $sformatf("done actual=%b expected=1", done));
    @(negedge clk);
    chk("R7", !done && !busy, $sformatf("after done actual=%b/%b expected=0/0", done, busy));
    done_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (done) done_cnt++;
      @(negedge clk);
    end
    chk("R7", done_cnt == 0, $sformatf("stray done actual=%0d expected=0", done_cnt));
  endtask

  task automatic test_hold();
    logic [31:0] r;
    bit tout;
    convert(to_code(20.0), r, tout);
    db = to_code(-40.0);
    repeat (40) @(negedge clk);
    chk("R8", res == r, $sformatf("hold actual=%h expected=%h", res, r));
  endtask

  task automatic test_busy_start();
    int done_cnt;
    real e, diff;
    logic [31:0] r;
    @(negedge clk);
    db = to_code(20.0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    db = to_code(40.0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < OP_TIMEOUT && !done; i++) @(negedge clk);
    r = res;
    e = 10.0 * 1048576.0;
    diff = $itor(r) - e;
    if (diff < 0.0) diff = -diff;
    chk("R9", done && diff <= 16.0 + 2.0e-4 * e, $sformatf("actual=%0d expected=%f", r, e));
    done_cnt = 0;
    @(negedge clk);
    for (int i = 0; i < 1500; i++) begin
      if (done) done_cnt++;
      @(negedge clk);
    end
    chk("R9", done_cnt == 0 && res == r,
        $sformatf("extra done actual=%0d/%h expected=0/%h", done_cnt, res, r));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_unity();
    test_floor();
    test_arg_limits();
    test_accuracy();
    test_halvings();
    test_handshake();
    test_hold();
    test_busy_start();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule